// File: doc/BRIEF.md
# Low-Power Operating-Point Sequencer

This block is a per-package controller that moves the core clock ratio and the core supply voltage code between a nominal operating point and a reduced one. It watches a halted flag from every core and a software enable bit. When all cores are idle and the feature is enabled, it lowers the ratio first and the voltage code second. A break event brings the package back: the voltage code is raised first and the ratio second. The external bus clock is never touched. Only the internal ratio code changes.

Each step hands a new code to a downstream ratio unit or voltage unit. It holds a request level until that unit acknowledges. A programmable step timeout raises a sticky error flag. The codes in use when entry begins are captured, and exactly those codes are put back on exit, whatever the nominal inputs do meanwhile. Snoop requests are acknowledged in every state, the low-power state included.

Top module: `lps_seq_top`

## Requirements
- R1: Entry starts only when every bit of `core_halted` is 1 and `lp_enable` is 1. The `lp_state` encoding is: 0 normal, 1 lowering ratio, 2 lowering voltage, 3 low power, 4 raising voltage, 5 raising ratio.
- R2: When only some cores are halted, or when `lp_enable` is 0, the block stays in state 0. Its codes keep following `nom_ratio` and `nom_vid`.
- R3: On entry, `ratio_code` takes `low_ratio` in state 1. Only after `ratio_ack` does `vid_code` take `low_vid`, in state 2. State 3 is reached only after `vid_ack`.
- R4: A `break_evt` pulse in state 3 starts the exit sequence in the next cycle (state 4).
- R5: On exit, `vid_code` is restored in state 4. Only after `vid_ack` is `ratio_code` restored, in state 5. State 0 follows `ratio_ack`.
- R6: The restored codes equal the codes that were applied when entry began, even if `nom_ratio` or `nom_vid` changed while in low power. In state 0, the codes follow the nominal inputs with one cycle of delay.
- R7: `snoop_ack` is 1 in the cycle after any cycle with `snoop_req` at 1, in every state.
- R8: A `break_evt` during state 1 or 2 lets the current step finish at its acknowledge. The block then goes straight to the exit step that undoes what was changed: state 5 from state 1, state 4 from state 2. State 3 is never entered.
- R9: When a request waits `tmo_limit` cycles without an acknowledge, `seq_error` goes to 1 and stays at 1 until reset. A `tmo_limit` of 0 turns the check off.
- R10: `ratio_req` is 1 exactly in states 1 and 5. `vid_req` is 1 exactly in states 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_halted | input | NCORES | Per-core halted flag |
| lp_enable | input | 1 | Software enable for the low-power state |
| break_evt | input | 1 | Wake event pulse |
| nom_ratio | input | RATIO_W | Nominal core ratio code |
| nom_vid | input | VID_W | Nominal voltage code |
| low_ratio | input | RATIO_W | Reduced core ratio code |
| low_vid | input | VID_W | Reduced voltage code |
| ratio_ack | input | 1 | Ratio unit has applied the ratio code |
| vid_ack | input | 1 | Voltage unit has applied the voltage code |
| tmo_limit | input | TMO_W | Step timeout in cycles, 0 disables |
| snoop_req | input | 1 | Snoop request |
| ratio_code | output | RATIO_W | Target core ratio code |
| vid_code | output | VID_W | Target voltage code |
| ratio_req | output | 1 | Ratio change pending |
| vid_req | output | 1 | Voltage change pending |
| lp_state | output | 3 | Sequencer state |
| lp_active | output | 1 | Not in the normal state |
| seq_error | output | 1 | Sticky step timeout flag |
| snoop_ack | output | 1 | Snoop acknowledge |

## Verification
The scoreboard records every change of the ratio and voltage code pair and compares it with the sequence the requirements predict. This exposes any swap of step order or any skipped step. Four patterns are used. A partial halt and a disabled enable are used to tell the qualifying condition apart from a single halted core. A full entry/exit round trip is run while the nominal ratio changes, which separates restoring saved codes from re-reading the inputs. Break events are placed during the ratio step and during the voltage step, to show that only the changed half is undone. A withheld acknowledge is used, which separates a real timeout from a slow but legal response.

// File: rtl/lps_pkg.sv
// Shared state encoding for the low-power operating-point sequencer.
package lps_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_E_RATIO = 3'd1,
        ST_E_VID   = 3'd2,
        ST_LOW     = 3'd3,
        ST_X_VID   = 3'd4,
        ST_X_RATIO = 3'd5
    } lps_state_e;
endpackage

// File: rtl/lps_halt_qual.sv
// Entry qualifier: asserts go when every core reports halted and the
// feature is enabled. Assumes halted flags are already synchronous to clk.
module lps_halt_qual #(
    parameter int NCORES = 2
) (
    input  logic [NCORES-1:0] core_halted,
    input  logic              lp_enable,
    output logic              go
);
    // One AND term per core, chained so any running core blocks entry.
    logic [NCORES:0] chain;
    assign chain[0] = lp_enable;
    for (genvar g = 0; g < NCORES; g++) begin : g_core
        assign chain[g+1] = chain[g] & core_halted[g];
    end
    assign go = chain[NCORES];
endmodule

// File: rtl/lps_step_timer.sv
// Step watchdog: counts cycles a request waits for its acknowledge and
// sets a sticky error when the count reaches the limit. Limit 0 disables.
module lps_step_timer #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             done,
    input  logic [TMO_W-1:0] limit,
    output logic             err
);
    logic [TMO_W-1:0] wait_cnt;
    logic [TMO_W-1:0] cnt_nx;

    assign cnt_nx = wait_cnt + 1'b1;

    // Wait counter: restarts on every completed step or idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || done) wait_cnt <= '0;
        else if (cnt_nx != '0)       wait_cnt <= cnt_nx;
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else if (busy && !done && limit != '0 && cnt_nx == limit) err <= 1'b1;
    end

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/lps_seq_fsm.sv
// Operating-point sequencer: lowers ratio then voltage on entry, raises
// voltage then ratio on exit, each step waiting for its unit's acknowledge.
// Assumes acknowledges are only meaningful while the matching request is high.
module lps_seq_fsm
    import lps_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int VID_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               break_evt,
    input  logic [RATIO_W-1:0] nom_ratio,
    input  logic [VID_W-1:0]   nom_vid,
    input  logic [RATIO_W-1:0] low_ratio,
    input  logic [VID_W-1:0]   low_vid,
    input  logic               ratio_ack,
    input  logic               vid_ack,
    output logic [RATIO_W-1:0] ratio_code,
    output logic [VID_W-1:0]   vid_code,
    output logic               ratio_req,
    output logic               vid_req,
    output lps_state_e         st
);
    logic [RATIO_W-1:0] sv_ratio;
    logic [VID_W-1:0]   sv_vid;
    logic [VID_W-1:0]   lo_vid;
    logic               brk_pend;
    logic               abort;

    assign abort     = brk_pend | break_evt;
    assign ratio_req = (st == ST_E_RATIO) || (st == ST_X_RATIO);
    assign vid_req   = (st == ST_E_VID)   || (st == ST_X_VID);

    // State, applied codes, saved codes and pending-break tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_NORMAL;
            ratio_code <= '0;
            vid_code   <= '0;
            sv_ratio   <= '0;
            sv_vid     <= '0;
            lo_vid     <= '0;
            brk_pend   <= 1'b0;
        end else begin
            case (st)
                ST_NORMAL: begin
                    brk_pend <= 1'b0;
                    vid_code <= nom_vid;
                    if (go) begin
                        st         <= ST_E_RATIO;
                        sv_ratio   <= ratio_code;
                        sv_vid     <= vid_code;
                        lo_vid     <= low_vid;
                        ratio_code <= low_ratio;
                        vid_code   <= vid_code;
                    end else begin
                        ratio_code <= nom_ratio;
                    end
                end
                ST_E_RATIO: begin
                    if (break_evt) brk_pend <= 1'b1;
                    if (ratio_ack) begin
                        if (abort) begin
                            st         <= ST_X_RATIO;
                            ratio_code <= sv_ratio;
                        end else begin
                            st       <= ST_E_VID;
                            vid_code <= lo_vid;
                        end
                    end
                end
                ST_E_VID: begin
                    if (break_evt) brk_pend <= 1'b1;
                    if (vid_ack) begin
                        if (abort) begin
                            st       <= ST_X_VID;
                            vid_code <= sv_vid;
                        end else begin
                            st <= ST_LOW;
                        end
                    end
                end
                ST_LOW: begin
                    if (break_evt) begin
                        st       <= ST_X_VID;
                        vid_code <= sv_vid;
                    end
                end
                ST_X_VID: begin
                    if (vid_ack) begin
                        st         <= ST_X_RATIO;
                        ratio_code <= sv_ratio;
                    end
                end
                ST_X_RATIO: begin
                    if (ratio_ack) st <= ST_NORMAL;
                end
                default: st <= ST_NORMAL;
            endcase
        end
    end

    p_entry_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_E_RATIO && $past(st) == ST_NORMAL) |-> $past(go));
    p_entry_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_E_VID && $past(st) != ST_E_VID) |-> ($past(st) == ST_E_RATIO && $past(ratio_ack)));
    p_low_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW) |-> (vid_code == lo_vid));
    p_exit_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW && break_evt) |=> (st == ST_X_VID));
    p_exit_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_X_RATIO) |-> (vid_code == sv_vid));
    p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORMAL && $past(st) == ST_X_RATIO) |-> (ratio_code == sv_ratio && vid_code == sv_vid));
    p_abort_skips_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_E_VID && brk_pend && vid_ack) |=> (st == ST_X_VID));
    p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ratio_req, vid_req}));
endmodule

// File: rtl/lps_seq_top.sv
// Top of the low-power operating-point sequencer: entry qualifier, step
// sequencer, step watchdog and a snoop responder that runs in every state.
module lps_seq_top
    import lps_pkg::*;
#(
    parameter int NCORES  = 2,
    parameter int RATIO_W = 6,
    parameter int VID_W   = 7,
    parameter int TMO_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCORES-1:0]  core_halted,
    input  logic               lp_enable,
    input  logic               break_evt,
    input  logic [RATIO_W-1:0] nom_ratio,
    input  logic [VID_W-1:0]   nom_vid,
    input  logic [RATIO_W-1:0] low_ratio,
    input  logic [VID_W-1:0]   low_vid,
    input  logic               ratio_ack,
    input  logic               vid_ack,
    input  logic [TMO_W-1:0]   tmo_limit,
    input  logic               snoop_req,
    output logic [RATIO_W-1:0] ratio_code,
    output logic [VID_W-1:0]   vid_code,
    output logic               ratio_req,
    output logic               vid_req,
    output logic [2:0]         lp_state,
    output logic               lp_active,
    output logic               seq_error,
    output logic               snoop_ack
);
    logic       go;
    lps_state_e st;
    logic       step_done;

    lps_halt_qual #(.NCORES(NCORES)) u_qual (
        .core_halted (core_halted),
        .lp_enable   (lp_enable),
        .go          (go)
    );

    lps_seq_fsm #(.RATIO_W(RATIO_W), .VID_W(VID_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .break_evt  (break_evt),
        .nom_ratio  (nom_ratio),
        .nom_vid    (nom_vid),
        .low_ratio  (low_ratio),
        .low_vid    (low_vid),
        .ratio_ack  (ratio_ack),
        .vid_ack    (vid_ack),
        .ratio_code (ratio_code),
        .vid_code   (vid_code),
        .ratio_req  (ratio_req),
        .vid_req    (vid_req),
        .st         (st)
    );

    assign step_done = (ratio_req & ratio_ack) | (vid_req & vid_ack);

    lps_step_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (ratio_req | vid_req),
        .done  (step_done),
        .limit (tmo_limit),
        .err   (seq_error)
    );

    assign lp_state  = st;
    assign lp_active = (st != ST_NORMAL);

    // Snoop responder: independent of the operating point.
    always_ff @(posedge clk) begin
        if (!rst_n) snoop_ack <= 1'b0;
        else        snoop_ack <= snoop_req;
    end

    p_snoop_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_req |=> snoop_ack);
endmodule

// File: tb/lps_seq_top_tb.sv
module lps_seq_top_tb;
    localparam int RW = 6;
    localparam int VW = 7;
    localparam int TW = 12;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] core_halted = '0;
    logic lp_enable = 1'b0, break_evt = 1'b0, snoop_req = 1'b0;
    logic [RW-1:0] nom_ratio = 6'd20, low_ratio = 6'd6;
    logic [VW-1:0] nom_vid = 7'h30, low_vid = 7'h12;
    logic ratio_ack = 1'b0, vid_ack = 1'b0;
    logic [TW-1:0] tmo_limit = '0;
    logic [RW-1:0] ratio_code;
    logic [VW-1:0] vid_code;
    logic ratio_req, vid_req, lp_active, seq_error, snoop_ack;
    logic [2:0] lp_state;

    always #2.5 clk = ~clk;

    lps_seq_top #(.NCORES(2), .RATIO_W(RW), .VID_W(VW), .TMO_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .lp_enable(lp_enable),
        .break_evt(break_evt), .nom_ratio(nom_ratio), .nom_vid(nom_vid),
        .low_ratio(low_ratio), .low_vid(low_vid), .ratio_ack(ratio_ack),
        .vid_ack(vid_ack), .tmo_limit(tmo_limit), .snoop_req(snoop_req),
        .ratio_code(ratio_code), .vid_code(vid_code), .ratio_req(ratio_req),
        .vid_req(vid_req), .lp_state(lp_state), .lp_active(lp_active),
        .seq_error(seq_error), .snoop_ack(snoop_ack)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Acknowledge model for both downstream units.
    logic rsp_on = 1'b1;
    int rc = 0, vc = 0;
    always @(posedge clk) begin
        if (!rsp_on || !ratio_req || ratio_ack) begin rc <= 0; ratio_ack <= 1'b0; end
        else if (rc == DLY-1) ratio_ack <= 1'b1;
        else rc <= rc + 1;
        if (!rsp_on || !vid_req || vid_ack) begin vc <= 0; vid_ack <= 1'b0; end
        else if (vc == DLY-1) vid_ack <= 1'b1;
        else vc <= vc + 1;
    end

    // Scoreboard of expected code-pair changes.
    typedef struct packed { logic [RW-1:0] r; logic [VW-1:0] v; } pair_t;
    pair_t exp_q[$];
    pair_t last;
    bit mon_en = 1'b0;
    bit saw_low = 1'b0;

    task automatic push(input logic [RW-1:0] r, input logic [VW-1:0] v);
        exp_q.push_back('{r: r, v: v});
    endtask

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (lp_state == 3'd3) saw_low = 1'b1;
            if ({ratio_code, vid_code} != last) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R5 unexpected code change", {ratio_code, vid_code}, last);
                end else begin
                    pair_t e;
                    e = exp_q.pop_front();
                    chk({ratio_code, vid_code} == e, "R3/R5/R6 code sequence",
                        {ratio_code, vid_code}, e);
                end
                last = '{r: ratio_code, v: vid_code};
            end
        end
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic wait_state(input logic [2:0] s, input string tag);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (lp_state == s) return;
        end
        chk(1'b0, tag, lp_state, s);
    endtask

    task automatic pulse_break();
        break_evt = 1'b1;
        @(negedge clk);
        break_evt = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(lp_state == 3'd0 && !lp_active && !ratio_req && !vid_req && !seq_error,
            "reset state R1/R10", lp_state, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ratio_code == 20 && vid_code == 7'h30, "R6 follows nominal", ratio_code, 20);
        last = '{r: ratio_code, v: vid_code};
        mon_en = 1'b1;

        // R2: partial halt and disabled enable
        lp_enable = 1'b1; core_halted = 2'b01;
        repeat (10) @(negedge clk);
        chk(lp_state == 3'd0, "R2 partial halt no entry", lp_state, 0);
        lp_enable = 1'b0; core_halted = 2'b11;
        repeat (10) @(negedge clk);
        chk(lp_state == 3'd0, "R2 disabled no entry", lp_state, 0);

        // R1/R3/R4/R5/R6: full round trip with timeout disabled
        push(6, 7'h30); push(6, 7'h12);
        lp_enable = 1'b1;
        wait_state(3'd1, "R1 entry start");
        chk(ratio_req && !vid_req, "R10 ratio step request", {ratio_req, vid_req}, 2'b10);
        wait_state(3'd3, "R3 reach low");
        chk(ratio_code == 6 && vid_code == 7'h12, "R3 low codes", {ratio_code, vid_code}, {6'd6, 7'h12});
        core_halted = 2'b00;
        nom_ratio = 6'd25;
        snoop_req = 1'b1;
        @(negedge clk);
        snoop_req = 1'b0;
        chk(snoop_ack == 1'b1, "R7 snoop served in low", snoop_ack, 1);
        push(6, 7'h30); push(20, 7'h30); push(25, 7'h30);
        pulse_break();
        chk(lp_state == 3'd4 && vid_req && !ratio_req, "R4 exit starts", lp_state, 4);
        wait_state(3'd0, "R5 exit done");
        drain("R6 restore then follow");
        chk(ratio_code == 25, "R6 follows new nominal", ratio_code, 25);
        chk(!seq_error, "R9 limit zero disables", seq_error, 0);

        // R8: break during ratio step
        tmo_limit = 12'd10;
        saw_low = 1'b0;
        push(6, 7'h30); push(25, 7'h30);
        core_halted = 2'b11;
        wait_state(3'd1, "R8 enter ratio step");
        core_halted = 2'b00;
        pulse_break();
        wait_state(3'd5, "R8 ratio abort to raise ratio");
        wait_state(3'd0, "R8 ratio abort done");
        drain("R8 ratio abort sequence");
        chk(!saw_low, "R8 low never entered (ratio)", saw_low, 0);

        // R8: break during voltage step
        saw_low = 1'b0;
        push(6, 7'h30); push(6, 7'h12); push(6, 7'h30); push(25, 7'h30);
        core_halted = 2'b11;
        wait_state(3'd2, "R8 enter voltage step");
        core_halted = 2'b00;
        pulse_break();
        wait_state(3'd4, "R8 voltage abort to raise voltage");
        wait_state(3'd0, "R8 voltage abort done");
        drain("R8 voltage abort sequence");
        chk(!saw_low, "R8 low never entered (voltage)", saw_low, 0);
        chk(!seq_error, "R9 no error on timely acks", seq_error, 0);

        // R9: withheld acknowledge
        tmo_limit = 12'd3;
        rsp_on = 1'b0;
        push(6, 7'h30); push(6, 7'h12);
        core_halted = 2'b11;
        wait_state(3'd1, "R9 enter");
        repeat (5) @(negedge clk);
        chk(seq_error, "R9 timeout flagged", seq_error, 1);
        chk(lp_state == 3'd1, "R3 waits for ack", lp_state, 1);
        tmo_limit = 12'd0;
        rsp_on = 1'b1;
        wait_state(3'd3, "R9 finish entry");
        core_halted = 2'b00;
        push(6, 7'h30); push(25, 7'h30);
        pulse_break();
        wait_state(3'd0, "R9 exit");
        drain("R9 sequence after timeout");
        chk(seq_error, "R9 error sticky", seq_error, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule